// File: doc/BRIEF.md
# Clock Controller Register Bank

This block holds the control and status words of a clock control unit in a 4 KiB address window. It is reached through a 32-bit word bus that has a separate write channel and a separate read channel. There are 26 word registers by default. Each one starts from its own fixed value after reset. Each one also has its own write rule: the whole word is stored, only a masked part is stored, a masked part is stored with one bit held at one, or the register cannot be written at all. The register index is the byte address divided by four.

The bank decodes fields from two of its registers and drives them straight to the downstream clock logic:
- From the main control word (index 0): the reference-source select, the fast-reference enable, the PLL enable and a main-clock choice between the PLL output and the PLL reference path.
- From the first post-divider word (index 1): the bus clock divide ratio, the peripheral clock divide ratio and their product.

Any access the bank cannot carry out is dropped. It produces one error pulse on the cycle after the access. This covers writes to read-only or absent registers, reads beyond the last register, misaligned addresses and partial-word writes.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, the registers read as follows, and every other index below 26 reads zero:

  | Index | Reset value |
  |-------|-------------|
  | 0 | 0x074B0B7D |
  | 1 | 0xFF870B48 |
  | 2 | 0x49FCFE7F |
  | 3 | 0x007F0000 |
  | 4 | 0x04001800 |
  | 5 | 0x04051C03 |
  | 6 | 0x04043001 |
  | 7 | 0x00000280 |
  | 8, 9, 10, 11 | 0xFFFFFFFF |
  | 18 | 0x00004040 |
  | 23 | 0x80209828 |
  | 24 | 0x00AA0000 |
  | 25 | 0x00000285 |

  Before the first read, rdData is zero.
- R2: A write to index 0 stores the write data ANDed with 0x3B6FDFFF, with bit 26 forced to one.
- R3: A write to index 1 stores the data ANDed with 0xFF9F3FFF. A write to index 4 or index 6 stores the data ANDed with 0xBFFF3FFF.
- R4: A write to index 2, 8, 9 or 10 stores all 32 bits unchanged.
- R5: A write to any other index below 26 leaves the register unchanged and raises the error pulse.
- R6: A read of an index at or above 26 returns zero and raises the error pulse. A write to such an index has no effect.
- R7: A write whose byte strobe is not 4'hF, or any access whose address bits [1:0] are not zero, changes no register and raises the error pulse. A misaligned read returns zero.
- R8: rdData updates on the clock edge that samples rdEn high, and it holds its value while rdEn is low. A read and a write to the same register in one cycle return the value from before the write.
- R9: Decoded from index 0:
  - refSelSrc is bits [2:1].
  - fpmEnable is bit 0.
  - pllEnable is bit 3.
  - mainSelPll is high only when bit 3 is one and bit 7 is zero.
- R10: Decoded from index 1:
  - busDivRatio is bits [5:3] plus one.
  - perDivRatio is bits [7:6] plus one.
  - perTotalRatio is their product, meaning the peripheral clock is divided after the bus divider.
- R11: accErr is high for exactly the one cycle after an invalid access, and low after valid accesses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrAddr | input | 12 | Write byte address |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Write byte strobes; only 4'hF is accepted |
| rdEn | input | 1 | Read request |
| rdAddr | input | 12 | Read byte address |
| rdData | output | 32 | Registered read data |
| accErr | output | 1 | One-cycle pulse after an invalid access |
| refSelSrc | output | 2 | Reference source select field |
| fpmEnable | output | 1 | Fast reference multiplier enable |
| pllEnable | output | 1 | Main PLL enable |
| mainSelPll | output | 1 | Main clock taken from the PLL output when high, from the reference path when low |
| busDivRatio | output | 4 | Bus clock divide ratio (1..8) |
| perDivRatio | output | 3 | Peripheral divide ratio applied after the bus divider (1..4) |
| perTotalRatio | output | 6 | Overall peripheral divide ratio from the main clock |

## Verification
The checker assumes three things about the inputs:
- wrEn and rdEn are low while reset is asserted.
- Each address, data and strobe value stays stable around the clock edge that samples it.
- A read at address zero always targets the control word, so its forced bit must show in the returned data.

The stimulus changes every input on the falling edge and keeps both enables low during reset. It reaches every index of the window for reads. It writes indices up to 31 with several patterns, including partial strobes and misaligned addresses. Reads and writes are issued in the same cycle only where the ordering rule is the thing under test.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int STRB_W = DATA_W / 8;

  // fixed register indices the exported fields come from
  localparam int CTL_IDX = 0;
  localparam int DIV_IDX = 1;

  // field positions inside the control and divider words
  localparam int FPM_BIT     = 0;
  localparam int REFSRC_LSB  = 1;
  localparam int PLLEN_BIT   = 3;
  localparam int MODESEL_BIT = 7;
  localparam int BUSDIV_LSB  = 3;
  localparam int BUSDIV_W    = 3;
  localparam int PERDIV_LSB  = 6;
  localparam int PERDIV_W    = 2;

  typedef struct packed {
    logic             wrGo;
    logic [IDX_W-1:0] wrIdx;
    logic             rdGo;
    logic             rdOk;
    logic [IDX_W-1:0] rdIdx;
    logic             badAccess;
  } ctlStrobes_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    case (idx)
      0:              return 32'h074B0B7D;
      1:              return 32'hFF870B48;
      2:              return 32'h49FCFE7F;
      3:              return 32'h007F0000;
      4:              return 32'h04001800;
      5:              return 32'h04051C03;
      6:              return 32'h04043001;
      7:              return 32'h00000280;
      8, 9, 10, 11:   return 32'hFFFFFFFF;
      18:             return 32'h00004040;
      23:             return 32'h80209828;
      24:             return 32'h00AA0000;
      25:             return 32'h00000285;
      default:        return '0;
    endcase
  endfunction

  function automatic logic isWritable(input int idx);
    case (idx)
      0, 1, 2, 4, 6, 8, 9, 10: return 1'b1;
      default:                 return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] writeMask(input int idx);
    case (idx)
      0:       return 32'h3B6FDFFF;
      1:       return 32'hFF9F3FFF;
      4, 6:    return 32'hBFFF3FFF;
      2, 8, 9, 10: return 32'hFFFFFFFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] forceBits(input int idx);
    case (idx)
      0:       return 32'h04000000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int NUM_REGS = 26
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrobes_t       strobes
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             wrShapeOk;
  logic             wrTargetOk;
  logic             wrGo;
  logic             rdOk;

  assign wrIdx = wrAddr[ADDR_W-1:2];
  assign rdIdx = rdAddr[ADDR_W-1:2];

  always_comb begin
    wrShapeOk  = (wrAddr[1:0] == 2'b00) && (wrStrb == '1);
    wrTargetOk = (wrIdx <= LAST_IDX) && isWritable(int'(wrIdx));
    wrGo       = wrEn && wrShapeOk && wrTargetOk;
    rdOk       = (rdAddr[1:0] == 2'b00) && (rdIdx <= LAST_IDX);
  end

  always_comb begin
    strobes.wrGo      = wrGo;
    strobes.wrIdx     = wrIdx;
    strobes.rdGo      = rdEn;
    strobes.rdOk      = rdOk;
    strobes.rdIdx     = rdIdx;
    strobes.badAccess = (wrEn && !wrGo) || (rdEn && !rdOk);
  end

endmodule

// File: rtl/clkctl_datapath.sv
module clkctl_datapath
  import clkctl_pkg::*;
#(
  parameter int NUM_REGS = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              accErr,
  output logic [DATA_W-1:0] ctlWord,
  output logic [DATA_W-1:0] divWord
);

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [DATA_W-1:0] RST_VAL = resetValue(g);
    localparam logic [DATA_W-1:0] MASK    = writeMask(g);
    localparam logic [DATA_W-1:0] FORCE   = forceBits(g);
    logic [DATA_W-1:0] q;

    if (isWritable(g)) begin : gRw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= RST_VAL;
        end else if (strobes.wrGo && (strobes.wrIdx == IDX_W'(g))) begin
          q <= (wrData & MASK) | FORCE;
        end
      end
    end else begin : gRo
      assign q = RST_VAL;
    end

    assign regFile[g] = q;
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (strobes.rdIdx == IDX_W'(k)) rdMux = regFile[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      accErr <= 1'b0;
    end else begin
      accErr <= strobes.badAccess;
      if (strobes.rdGo) rdData <= strobes.rdOk ? rdMux : '0;
    end
  end

  assign ctlWord = regFile[CTL_IDX];
  assign divWord = regFile[DIV_IDX];

endmodule

// File: rtl/clkctl_fields.sv
module clkctl_fields
  import clkctl_pkg::*;
(
  input  logic [DATA_W-1:0]   ctlWord,
  input  logic [DATA_W-1:0]   divWord,
  output logic [1:0]          refSelSrc,
  output logic                fpmEnable,
  output logic                pllEnable,
  output logic                mainSelPll,
  output logic [BUSDIV_W:0]   busDivRatio,
  output logic [PERDIV_W:0]   perDivRatio,
  output logic [BUSDIV_W+PERDIV_W+1:0] perTotalRatio
);

  localparam int TOT_W = BUSDIV_W + PERDIV_W + 2;

  always_comb begin
    refSelSrc   = ctlWord[REFSRC_LSB +: 2];
    fpmEnable   = ctlWord[FPM_BIT];
    pllEnable   = ctlWord[PLLEN_BIT];
    mainSelPll  = ctlWord[PLLEN_BIT] && !ctlWord[MODESEL_BIT];
    busDivRatio = {1'b0, divWord[BUSDIV_LSB +: BUSDIV_W]} + 1'b1;
    perDivRatio = {1'b0, divWord[PERDIV_LSB +: PERDIV_W]} + 1'b1;
    perTotalRatio = TOT_W'(busDivRatio) * TOT_W'(perDivRatio);
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int NUM_REGS = 26
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [11:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  wrStrb,
  input  logic        rdEn,
  input  logic [11:0] rdAddr,
  output logic [31:0] rdData,
  output logic        accErr,
  output logic [1:0]  refSelSrc,
  output logic        fpmEnable,
  output logic        pllEnable,
  output logic        mainSelPll,
  output logic [3:0]  busDivRatio,
  output logic [2:0]  perDivRatio,
  output logic [5:0]  perTotalRatio
);

  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] ctlWord;
  logic [DATA_W-1:0] divWord;

  clkctl_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrStrb  (wrStrb),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .strobes (strobes)
  );

  clkctl_datapath #(.NUM_REGS(NUM_REGS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData),
    .accErr  (accErr),
    .ctlWord (ctlWord),
    .divWord (divWord)
  );

  clkctl_fields uFields (
    .ctlWord       (ctlWord),
    .divWord       (divWord),
    .refSelSrc     (refSelSrc),
    .fpmEnable     (fpmEnable),
    .pllEnable     (pllEnable),
    .mainSelPll    (mainSelPll),
    .busDivRatio   (busDivRatio),
    .perDivRatio   (perDivRatio),
    .perTotalRatio (perTotalRatio)
  );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int NUM_REGS = 26
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [11:0] wrAddr,
  input logic [3:0]  wrStrb,
  input logic        rdEn,
  input logic [11:0] rdAddr,
  input logic [31:0] rdData,
  input logic        accErr,
  input logic        pllEnable,
  input logic        mainSelPll,
  input logic [3:0]  busDivRatio,
  input logic [2:0]  perDivRatio,
  input logic [5:0]  perTotalRatio
);

  localparam logic [9:0] LAST_IDX = 10'(NUM_REGS - 1);

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(wrEn || rdEn)); // R11

  AST_RDDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R8

  AST_FORCED_BIT_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 12'h000) |=> rdData[26]); // R2

  AST_OUT_OF_RANGE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr[11:2] > LAST_IDX) |=> (rdData == 32'h0 && accErr)); // R6

  AST_PARTIAL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrb != 4'hF) |=> accErr); // R7

  AST_SEL_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rstN)
    mainSelPll |-> pllEnable); // R9

  AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busDivRatio != 4'd0) && (perDivRatio != 3'd0)); // R10

  AST_RATIO_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    perTotalRatio == 6'(busDivRatio) * 6'(perDivRatio)); // R10

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .wrAddr        (wrAddr),
  .wrStrb        (wrStrb),
  .rdEn          (rdEn),
  .rdAddr        (rdAddr),
  .rdData        (rdData),
  .accErr        (accErr),
  .pllEnable     (pllEnable),
  .mainSelPll    (mainSelPll),
  .busDivRatio   (busDivRatio),
  .perDivRatio   (perDivRatio),
  .perTotalRatio (perTotalRatio)
);

// File: tb/sim_clkctl_regbank.sv
`timescale 1ns/1ps
module sim_clkctl_regbank;

  localparam int NREG = 26;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrStrb = '0;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        accErr;
  logic [1:0]  refSelSrc;
  logic        fpmEnable;
  logic        pllEnable;
  logic        mainSelPll;
  logic [3:0]  busDivRatio;
  logic [2:0]  perDivRatio;
  logic [5:0]  perTotalRatio;

  int total = 0;
  int bad = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  clkctl_regbank #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrb(wrStrb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .accErr(accErr), .refSelSrc(refSelSrc), .fpmEnable(fpmEnable),
    .pllEnable(pllEnable), .mainSelPll(mainSelPll), .busDivRatio(busDivRatio),
    .perDivRatio(perDivRatio), .perTotalRatio(perTotalRatio)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rstVal(input int idx);
    case (idx)
      0: return 32'h074B0B7D;  1: return 32'hFF870B48;
      2: return 32'h49FCFE7F;  3: return 32'h007F0000;
      4: return 32'h04001800;  5: return 32'h04051C03;
      6: return 32'h04043001;  7: return 32'h00000280;
      8, 9, 10, 11: return 32'hFFFFFFFF;
      18: return 32'h00004040; 23: return 32'h80209828;
      24: return 32'h00AA0000; 25: return 32'h00000285;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit canWrite(input int idx);
    return idx == 0 || idx == 1 || idx == 2 || idx == 4 || idx == 6 ||
           idx == 8 || idx == 9 || idx == 10;
  endfunction

  function automatic logic [31:0] applyWrite(input int idx, input logic [31:0] old,
                                             input logic [31:0] d);
    case (idx)
      0: return (d & 32'h3B6FDFFF) | 32'h04000000;
      1: return d & 32'hFF9F3FFF;
      4, 6: return d & 32'hBFFF3FFF;
      2, 8, 9, 10: return d;
      default: return old;
    endcase
  endfunction

  function automatic string reqFor(input int idx);
    if (idx == 0) return "R2";
    if (idx == 1 || idx == 4 || idx == 6) return "R3";
    if (idx == 2 || idx == 8 || idx == 9 || idx == 10) return "R4";
    if (idx < NREG) return "R5";
    return "R6";
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] s, output logic err);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrStrb = s;
    @(negedge clk);
    wrEn = 1'b0;
    err = accErr;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d,
                         output logic err);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
    err = accErr;
  endtask

  task automatic checkExports();
    logic [3:0] eBus;
    logic [2:0] ePer;
    eBus = {1'b0, model[1][5:3]} + 4'd1;
    ePer = {1'b0, model[1][7:6]} + 3'd1;
    check(refSelSrc == model[0][2:1], "R9 refSelSrc", 32'(refSelSrc), 32'(model[0][2:1]));
    check(fpmEnable == model[0][0], "R9 fpmEnable", 32'(fpmEnable), 32'(model[0][0]));
    check(pllEnable == model[0][3], "R9 pllEnable", 32'(pllEnable), 32'(model[0][3]));
    check(mainSelPll == (model[0][3] && !model[0][7]), "R9 mainSelPll",
          32'(mainSelPll), 32'(model[0][3] && !model[0][7]));
    check(busDivRatio == eBus, "R10 busDivRatio", 32'(busDivRatio), 32'(eBus));
    check(perDivRatio == ePer, "R10 perDivRatio", 32'(perDivRatio), 32'(ePer));
    check(32'(perTotalRatio) == 32'(eBus) * 32'(ePer), "R10 perTotalRatio",
          32'(perTotalRatio), 32'(eBus) * 32'(ePer));
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        e;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h00000000;
    pats[2] = 32'hA5C35A3C; pats[3] = 32'h3C5AC3A5;
    for (int i = 0; i < 32; i++) model[i] = rstVal(i);

    repeat (4) @(negedge clk);
    check(rdData == 32'h0, "R1 rdData in reset", rdData, 32'h0);
    check(accErr == 1'b0, "R11 accErr in reset", 32'(accErr), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R6: sweep every index of the window
    for (int i = 0; i < 1024; i++) begin
      busRead(12'(i << 2), d, e);
      if (i < NREG) begin
        check(d == model[i], "R1 reset value", d, model[i]);
        check(e == 1'b0, "R11 no error on valid read", 32'(e), 32'h0);
      end else begin
        check(d == 32'h0, "R6 out of range data", d, 32'h0);
        check(e == 1'b1, "R6 out of range error", 32'(e), 32'h1);
      end
    end
    checkExports();

    // R8: rdData holds while idle
    busRead(12'h008, d, e);
    repeat (3) @(negedge clk);
    check(rdData == model[2], "R8 hold while idle", rdData, model[2]);
    check(accErr == 1'b0, "R11 low when idle", 32'(accErr), 32'h0);

    // write sweep over indices 0..31 with several patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 32; i++) begin
        busWrite(12'(i << 2), pats[p] ^ 32'(i * 32'h01010101), 4'hF, e);
        check(e == !canWrite(i), {reqFor(i), " write error flag"}, 32'(e),
              32'(!canWrite(i)));
        if (i < NREG)
          model[i] = applyWrite(i, model[i], pats[p] ^ 32'(i * 32'h01010101));
        busRead(12'(i << 2), d, e);
        check(d == ((i < NREG) ? model[i] : 32'h0), {reqFor(i), " readback"}, d,
              (i < NREG) ? model[i] : 32'h0);
        checkExports();
      end
    end

    // R10: all divider field combinations
    for (int m = 0; m < 8; m++) begin
      for (int q = 0; q < 4; q++) begin
        logic [31:0] v;
        v = 32'hFF000000 | 32'(m << 3) | 32'(q << 6);
        busWrite(12'h004, v, 4'hF, e);
        model[1] = applyWrite(1, model[1], v);
        checkExports();
      end
    end

    // R9: every low-byte value of the control word
    for (int v = 0; v < 256; v++) begin
      busWrite(12'h000, 32'(v), 4'hF, e);
      model[0] = applyWrite(0, model[0], 32'(v));
      checkExports();
      if (v == 255) begin
        busRead(12'h000, d, e);
        check(d[26] == 1'b1, "R2 forced bit", d, model[0]);
      end
    end

    // R7: partial strobe and misaligned accesses
    busWrite(12'h008, 32'h12345678, 4'b0111, e);
    check(e == 1'b1, "R7 partial strobe error", 32'(e), 32'h1);
    busRead(12'h008, d, e);
    check(d == model[2], "R7 partial strobe ignored", d, model[2]);
    busWrite(12'h009, 32'h87654321, 4'hF, e);
    check(e == 1'b1, "R7 misaligned write error", 32'(e), 32'h1);
    busRead(12'h008, d, e);
    check(d == model[2], "R7 misaligned write ignored", d, model[2]);
    busRead(12'h00A, d, e);
    check(d == 32'h0 && e == 1'b1, "R7 misaligned read", d, 32'h0);

    // R11: pulse lasts one cycle
    @(negedge clk);
    check(accErr == 1'b0, "R11 pulse width", 32'(accErr), 32'h0);
    busWrite(12'h020, 32'h0, 4'hF, e);
    model[8] = 32'h0;
    check(e == 1'b0, "R11 valid write no error", 32'(e), 32'h0);

    // R8: read and write of one register in the same cycle
    wrEn = 1'b1; wrAddr = 12'h008; wrData = 32'hCAFEF00D; wrStrb = 4'hF;
    rdEn = 1'b1; rdAddr = 12'h008;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(rdData == model[2], "R8 same-cycle old value", rdData, model[2]);
    model[2] = 32'hCAFEF00D;
    busRead(12'h008, d, e);
    check(d == model[2], "R8 new value after", d, model[2]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule